// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Digit Counter

This block holds one decimal digit (0 to 9) in a 4-bit register and moves it one step per enabled clock edge, upward or downward as chosen by a direction input. A synchronous parallel load lets the digit start from any value. A reset input returns the digit to zero and overrides every other input.

Several copies form a multi-digit counter. All copies share the clock and the step strobe. The active-low carry output of each digit drives the active-low carry input of the next more significant digit. The carry output is combinational and goes low only when this digit is about to wrap and its own carry input is active. A higher digit therefore steps on the same edge on which the lower digit wraps, and every digit in the chain updates together.

Top module: `bcd_updown_decade`

## Requirements
- R1: With `rst` and `load_en` low, `cin_n` low, `step_en` high and `dir_up` high, each rising clock edge raises `q` by one, and a `q` of 9 becomes 0. `q[0]` is the least significant bit, and all four bits change together on the rising edge only.
- R2: Under the same conditions with `dir_up` low, each rising edge lowers `q` by one, and a `q` of 0 becomes 9.
- R3: When `rst` is high at a rising edge, `q` becomes 0 whatever the values of `load_en`, `step_en`, `cin_n`, `dir_up` and `preset`.
- R4: When `rst` is low and `load_en` is high at a rising edge, `q` takes the value of `preset`, whatever the values of `step_en` and `cin_n`.
- R5: When `rst` and `load_en` are low and either `cin_n` is high or `step_en` is low, `q` keeps its value across the edge.
- R6: `cout_n` is low exactly when `cin_n` is low and either `dir_up` is high with `q` equal to 9, or `dir_up` is low with `q` equal to 0. It does not depend on `step_en`, and it follows input changes within the same cycle.
- R7: A `preset` above 9 is loaded unchanged, and the next upward step from any value above 9 gives 0.
- R8: A downward step from any value above 9 gives 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous active-high clear to zero; highest priority |
| step_en | input | 1 | Count strobe; high enables a step on this edge |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| load_en | input | 1 | Synchronous parallel load of `preset` |
| preset | input | 4 | Value loaded when `load_en` is high |
| cin_n | input | 1 | Active-low carry/enable input from the lower digit |
| q | output | 4 | Current digit, bit 0 least significant |
| cout_n | output | 1 | Active-low carry to the next higher digit |

## Verification
The properties assume that `rst` is high at the first clock edge, so that `q` is defined before any step or hold property is evaluated. The bench meets this by driving `rst` high from time zero. The properties also assume that inputs change only away from the rising edge, and the bench drives every input just after the falling edge. The step properties apply only to values from 0 to 9. The bench loads presets from 10 to 15 on purpose and checks those cases against its own model. Its random phase spans the full 4-bit preset range and every combination of control inputs.

// File: rtl/bcd_decade_pkg.sv
package bcd_decade_pkg;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t DIGIT_TOP  = digit_t'(DIGIT_MAX);
    localparam digit_t DIGIT_ZERO = '0;
    localparam digit_t DIGIT_ONE  = digit_t'(1);

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_STEP
    } dec_op_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic strobe;
        logic cin_n;
        dir_e dir;
    } ctrl_t;

    function automatic digit_t step_up(input digit_t v);
        if (v >= DIGIT_TOP)
            return DIGIT_ZERO;
        return digit_t'(v + DIGIT_ONE);
    endfunction

    function automatic digit_t step_down(input digit_t v);
        if (v == DIGIT_ZERO || v > DIGIT_TOP)
            return DIGIT_TOP;
        return digit_t'(v - DIGIT_ONE);
    endfunction

    function automatic logic at_terminal(input digit_t v, input dir_e d);
        return (d == DIR_UP) ? (v == DIGIT_TOP) : (v == DIGIT_ZERO);
    endfunction

endpackage

// File: rtl/bcd_decade_op.sv
module bcd_decade_op
    import bcd_decade_pkg::*;
(
    input  ctrl_t   ctrl,
    output dec_op_e op
);
    always_comb begin
        if (ctrl.clear)
            op = OP_CLEAR;
        else if (ctrl.load)
            op = OP_LOAD;
        else if (ctrl.strobe && !ctrl.cin_n)
            op = OP_STEP;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_decade_next.sv
module bcd_decade_next
    import bcd_decade_pkg::*;
(
    input  dec_op_e op,
    input  dir_e    dir,
    input  digit_t  cur,
    input  digit_t  preset,
    output digit_t  nxt
);
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = DIGIT_ZERO;
            OP_LOAD:  nxt = preset;
            OP_STEP:  nxt = (dir == DIR_UP) ? step_up(cur) : step_down(cur);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_decade_carry.sv
module bcd_decade_carry
    import bcd_decade_pkg::*;
(
    input  digit_t cur,
    input  dir_e   dir,
    input  logic   cin_n,
    output logic   cout_n
);
    always_comb cout_n = !(!cin_n && at_terminal(cur, dir));
endmodule

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade
    import bcd_decade_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                dir_up,
    input  logic                load_en,
    input  logic [DIGIT_W-1:0]  preset,
    input  logic                cin_n,
    output logic [DIGIT_W-1:0]  q,
    output logic                cout_n
);
    ctrl_t   ctrl;
    dec_op_e op;
    digit_t  cur_q;
    digit_t  nxt_q;

    always_comb begin
        ctrl.clear  = rst;
        ctrl.load   = load_en;
        ctrl.strobe = step_en;
        ctrl.cin_n  = cin_n;
        ctrl.dir    = dir_e'(dir_up);
    end

    bcd_decade_op u_op (
        .ctrl (ctrl),
        .op   (op)
    );

    bcd_decade_next u_next (
        .op     (op),
        .dir    (ctrl.dir),
        .cur    (cur_q),
        .preset (preset),
        .nxt    (nxt_q)
    );

    bcd_decade_carry u_carry (
        .cur    (cur_q),
        .dir    (ctrl.dir),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    always_ff @(posedge clk) begin
        cur_q <= nxt_q;
    end

    assign q = cur_q;
endmodule

// File: rtl/bcd_decade_chk.sv
module bcd_decade_chk
    import bcd_decade_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic               dir_up,
    input logic               load_en,
    input logic [DIGIT_W-1:0] preset,
    input logic               cin_n,
    input logic [DIGIT_W-1:0] q,
    input logic               cout_n
);
    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    AST_CLEAR_TO_ZERO: assert property (@(posedge clk)
        rst_seen |-> q == DIGIT_ZERO); // R3

    AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (rst)
        load_en |=> q == $past(preset)); // R4

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!load_en && (cin_n || !step_en)) |=> $stable(q)); // R5

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load_en && step_en && dir_up && !cout_n) |=> q == DIGIT_ZERO); // R6

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load_en && step_en && !dir_up && !cout_n) |=> q == DIGIT_TOP); // R6

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_en && step_en && !cin_n && dir_up && q < DIGIT_TOP)
        |=> q == digit_t'($past(q) + DIGIT_ONE)); // R1

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_en && step_en && !cin_n && !dir_up && q != DIGIT_ZERO && q <= DIGIT_TOP)
        |=> q == digit_t'($past(q) - DIGIT_ONE)); // R2
endmodule

bind bcd_updown_decade bcd_decade_chk i_chk (.*);

// File: tb/test_bcd_updown_decade.sv
module test_bcd_updown_decade;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       dir_up = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] preset = 4'd0;
    logic       cin_n = 1'b0;
    logic [3:0] q;
    logic       cout_n;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  ref_q    = 0;
    bit  ref_ok   = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_updown_decade i_bcd_updown_decade (
        .clk(clk), .rst(rst), .step_en(step_en), .dir_up(dir_up),
        .load_en(load_en), .preset(preset), .cin_n(cin_n),
        .q(q), .cout_n(cout_n)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One clock cycle: drive, check carry combinationally, then check q after the edge.
    task automatic cyc(input logic r, input logic s, input logic d,
                       input logic l, input int p, input logic c);
        int    nxt;
        int    exp_cout;
        string tag;
        @(negedge clk);
        rst = r; step_en = s; dir_up = d; load_en = l; preset = 4'(p); cin_n = c;
        #1;
        if (ref_ok) begin
            exp_cout = (!c && ((d && ref_q == 9) || (!d && ref_q == 0))) ? 0 : 1;
            check("R6", int'(cout_n), exp_cout);
        end
        if (r) begin
            nxt = 0; tag = "R3";
        end else if (l) begin
            nxt = p; tag = (p > 9) ? "R7" : "R4";
        end else if (s && !c) begin
            if (d) begin
                nxt = (ref_q >= 9) ? 0 : ref_q + 1;
                tag = (ref_q > 9) ? "R7" : "R1";
            end else begin
                nxt = (ref_q == 0 || ref_q > 9) ? 9 : ref_q - 1;
                tag = (ref_q > 9) ? "R8" : "R2";
            end
        end else begin
            nxt = ref_q; tag = "R5";
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (r || ref_ok) check(tag, int'(q), nxt);
        ref_q  = nxt;
        ref_ok = ref_ok || r;
    endtask

    initial begin
        // Reset state, with other inputs busy (R3)
        cyc(1, 1, 1, 1, 7, 0);
        cyc(1, 1, 0, 0, 3, 0);
        // Up count through two wraps (R1, R6)
        for (int i = 0; i < 22; i++) cyc(0, 1, 1, 0, 0, 0);
        // Inhibit by carry-in and by strobe (R5); carry-out at 9 with cin_n high stays high (R6)
        cyc(0, 0, 1, 1, 9, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 0);
        // Down count through two wraps (R2, R6)
        for (int i = 0; i < 23; i++) cyc(0, 1, 0, 0, 0, 0);
        // Load overrides strobe and carry-in (R4)
        cyc(0, 1, 1, 1, 5, 1);
        cyc(0, 1, 0, 1, 0, 0);
        // Reset overrides load (R3)
        cyc(0, 0, 1, 1, 6, 0);
        cyc(1, 1, 1, 1, 8, 0);
        // Presets above nine (R7, R8)
        for (int p = 10; p < 16; p++) begin
            cyc(0, 0, 1, 1, p, 0);
            cyc(0, 1, 1, 0, 0, 0);
            cyc(0, 0, 0, 1, p, 0);
            cyc(0, 1, 0, 0, 0, 0);
            cyc(0, 0, 1, 1, p, 0);
            cyc(0, 1, 1, 0, 0, 1);
        end
        // Random mix
        for (int i = 0; i < 600; i++) begin
            automatic int sel = int'($urandom_range(0, 19));
            cyc(sel == 0, $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
                sel == 1 || sel == 2, int'($urandom_range(0, 15)),
                $urandom_range(0, 4) == 0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule